// File: doc/BRIEF.md
# Serial Debug Command Engine

This block turns a stream of received bytes from a UART into register accesses and answers every complete request with a frame of transmit bytes. Each frame begins with an opcode that names a target unit. The engine decodes register read and register write requests, and it also decodes length-prefixed user messages. It drives write and read strobes towards the register banks outside the block. It forwards the payload of user messages byte by byte. It then builds the matching response frame and sends it out over a valid/ready byte interface.

The engine keeps six counters of its own, and each one saturates. Three of them count faults: unknown opcodes, access violations and timeouts. The other three count traffic: received bytes, transmitted bytes and parsed frames. A host reads these counters back as registers of two read-only units. If a request stops partway, an idle timer with a programmable limit throws away the partial frame, so the parser cannot stay stuck waiting for bytes that never come.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset, tx_valid, reg_wr, reg_rd and usr_valid are low and all six counters read zero.
- R2: A register request is opcode, then a register byte, where bit 7 set means write (followed by a 32-bit word, most significant byte first) and bit 7 clear means read; bits 6..0 select register 0..127. Opcodes: 0x01 control (write only), 0x03 status (read only), 0x05 user message, 0x07 error counters (read only), 0x09 traffic counters (read only).
- R3: A write to the control unit gives one reg_wr pulse with reg_unit 0, reg_num and reg_wdata from the request, and is acknowledged with the two bytes {0x02, register byte}.
- R4: A read of the status unit gives one reg_rd pulse with reg_unit 1 and reg_num, and returns {0x04, register byte, reg_rdata MSB first}, where reg_rdata is sampled in the same cycle as reg_rd.
- R5: An opcode outside the list in R2 is answered at once with {0x08, 0x01}, raises no strobe, and adds one to the unknown-opcode counter.
- R6: A read of the control unit, or a write to any read-only unit, is answered with {0x08, 0x02} after the whole request has arrived (a write still consumes its four data bytes). It raises no strobe and adds one to the access-violation counter.
- R7: A user frame is 0x05, a count N (0..255), then N payload bytes. Each payload byte appears on usr_data with a one-cycle usr_valid, in order, and the frame is answered with {0x06, N}.
- R8: If a frame is incomplete and idle_limit consecutive cycles pass with no received byte, the partial frame is discarded with no response and the timeout counter adds one. An idle_limit of 0 turns the timeout off.
- R9: Reading unit 0x07 registers 0, 1 and 2 returns the unknown-opcode, access-violation and timeout counts, in a 6-byte response with code 0x08. Registers 3 and above read as zero.
- R10: Reading unit 0x09 registers 0, 1 and 2 returns, with code 0x0A, the received-byte count (including the request's own bytes), the transmitted-byte count, and the count of frames parsed before this one.
- R11: Every counter stops at all-ones instead of wrapping.
- R12: tx_data holds steady while tx_valid is high and tx_ready is low. Bytes that arrive while a response is pending are dropped, though they still count as received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_limit | input | TMO_W | Idle cycles before a partial frame is discarded; 0 disables |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Response byte available |
| tx_ready | input | 1 | Sink accepts the response byte |
| tx_data | output | 8 | Response byte |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_unit | output | 2 | Target bank: 0 control, 1 status |
| reg_num | output | 7 | Register number inside the bank |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data from the status bank, same cycle as reg_rd |
| usr_valid | output | 1 | User payload byte valid |
| usr_data | output | 8 | User payload byte |

## Verification
A parser that has lost its frame position cannot hide for long. The next request gets an error frame or a header code that does not match, and the counter readback for that frame shows the fault in the unknown-opcode or violation count. A timer that fires too early or too late shows up either as a missing response or as an unexpected one within the idle limit plus one response time. A counter or shift register stepping wrong shows up in the very next readback of unit 0x07 or 0x09, or in the order of transmitted bytes under backpressure.

// File: rtl/dce_pkg.sv
`timescale 1ns/1ps
package dce_pkg;
  localparam logic [7:0] OP_CTRL  = 8'h01;
  localparam logic [7:0] OP_STAT  = 8'h03;
  localparam logic [7:0] OP_USER  = 8'h05;
  localparam logic [7:0] OP_ERR   = 8'h07;
  localparam logic [7:0] OP_STATS = 8'h09;
  localparam logic [7:0] RC_FAULT = 8'h08;
  localparam logic [7:0] CAUSE_UNKNOWN = 8'h01;
  localparam logic [7:0] CAUSE_ACCESS  = 8'h02;
  localparam int RSP_MAX_BYTES = 6;
  localparam int NUM_CNT = 6;
  // counter slots
  localparam int CI_UNK  = 0;
  localparam int CI_VIOL = 1;
  localparam int CI_TMO  = 2;
  localparam int CI_RXB  = 3;
  localparam int CI_TXB  = 4;
  localparam int CI_FRM  = 5;

  typedef enum logic [2:0] {
    P_OP, P_REG, P_DATA, P_LEN, P_PAY, P_EXEC, P_SEND
  } pstate_t;

  function automatic logic [7:0] resp_code(input logic [7:0] op);
    return op + 8'd1;
  endfunction

  function automatic logic is_reg_op(input logic [7:0] op);
    return (op == OP_CTRL) || (op == OP_STAT) || (op == OP_ERR) || (op == OP_STATS);
  endfunction

  function automatic logic access_ok(input logic [7:0] op, input logic wr);
    return wr ? (op == OP_CTRL) : (op != OP_CTRL);
  endfunction
endpackage

// File: rtl/dce_sat_cnt.sv
`timescale 1ns/1ps
module dce_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                  val <= '0;
    else if (inc && val != TOP)  val <= val + 1'b1;
  end

  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (val == TOP) |=> (val == TOP));
  // R11
  sat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(val));
endmodule

// File: rtl/dce_idle_timer.sv
`timescale 1ns/1ps
module dce_idle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         kick,
  input  logic [W-1:0] limit,
  output logic         expire
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic [W-1:0] idle_q;
  logic         enabled;

  assign enabled = (limit != '0);
  assign expire  = active && !kick && enabled && (idle_q == limit - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)                        idle_q <= '0;
    else if (!active || kick || expire) idle_q <= '0;
    else                               idle_q <= idle_q + ONE;
  end

  // R8
  idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && enabled) |-> (idle_q < limit));
endmodule

// File: rtl/dce_tx_frame.sv
`timescale 1ns/1ps
module dce_tx_frame #(
  parameter int MAXB = 6,
  localparam int LW = $clog2(MAXB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [8*MAXB-1:0] bytes,
  input  logic [LW-1:0]     len,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              busy
);
  logic [8*MAXB-1:0] sh_q;
  logic [LW-1:0]     left_q;
  logic              ev_sent;

  assign tx_valid = (left_q != '0);
  assign tx_data  = sh_q[8*MAXB-1 -: 8];
  assign busy     = tx_valid;
  assign ev_sent  = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= bytes;
      left_q <= len;
    end else if (ev_sent) begin
      sh_q   <= {sh_q[8*MAXB-9:0], 8'h00};
      left_q <= left_q - 1'b1;
    end
  end

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R12
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/dbg_cmd_engine.sv
`timescale 1ns/1ps
module dbg_cmd_engine
  import dce_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMO_W-1:0] idle_limit,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             reg_wr,
  output logic             reg_rd,
  output logic [1:0]       reg_unit,
  output logic [6:0]       reg_num,
  output logic [31:0]      reg_wdata,
  input  logic [31:0]      reg_rdata,
  output logic             usr_valid,
  output logic [7:0]       usr_data
);
  localparam int FRW = 8 * RSP_MAX_BYTES;
  localparam int LW  = $clog2(RSP_MAX_BYTES + 1);

  pstate_t     st;
  logic [7:0]  op_q, reg_q, len_q, left_q;
  logic [31:0] wdat_q;
  logic [1:0]  dcnt_q;

  // named internal events
  logic ev_unknown, ev_viol, ev_timeout, ev_frame, ev_txb;
  logic is_wr, acc_ok, parsing, tx_busy;

  logic [FRW-1:0] fr_bytes;
  logic [LW-1:0]  fr_len;
  logic           fr_load;

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
  logic [NUM_CNT-1:0]            cnt_inc;
  logic [2:0]                    cidx;
  logic [31:0]                   rd_val;

  assign is_wr   = reg_q[7];
  assign acc_ok  = access_ok(op_q, is_wr);
  assign parsing = (st == P_REG) || (st == P_DATA) || (st == P_LEN) || (st == P_PAY);

  assign ev_unknown = (st == P_OP) && rx_valid && !is_reg_op(rx_data) && (rx_data != OP_USER);
  assign ev_viol    = (st == P_EXEC) && !acc_ok;
  assign ev_txb     = tx_valid && tx_ready;
  assign ev_frame   = ev_unknown || (st == P_EXEC)
                   || ((st == P_LEN) && rx_valid && (rx_data == 8'h00))
                   || ((st == P_PAY) && rx_valid && (left_q == 8'd1));

  assign reg_wr    = (st == P_EXEC) && acc_ok && is_wr;
  assign reg_rd    = (st == P_EXEC) && acc_ok && !is_wr && (op_q == OP_STAT);
  assign reg_unit  = (op_q == OP_CTRL) ? 2'd0 : 2'd1;
  assign reg_num   = reg_q[6:0];
  assign reg_wdata = wdat_q;
  assign usr_valid = (st == P_PAY) && rx_valid;
  assign usr_data  = rx_data;

  // readback of the counters and the status bank
  always_comb begin
    cidx = {1'b0, reg_q[1:0]};
    if (op_q == OP_STATS) cidx = cidx + 3'd3;
    rd_val = '0;
    if (op_q == OP_STAT)
      rd_val = reg_rdata;
    else if (reg_q[6:0] < 7'd3)
      rd_val[CNT_W-1:0] = cnt_val[cidx];
  end

  // response builder
  always_comb begin
    fr_load  = 1'b0;
    fr_len   = '0;
    fr_bytes = '0;
    if (ev_unknown) begin
      fr_load  = 1'b1;
      fr_len   = LW'(2);
      fr_bytes = {RC_FAULT, CAUSE_UNKNOWN, 32'h0};
    end else if (st == P_EXEC) begin
      fr_load = 1'b1;
      if (!acc_ok) begin
        fr_len   = LW'(2);
        fr_bytes = {RC_FAULT, CAUSE_ACCESS, 32'h0};
      end else if (is_wr) begin
        fr_len   = LW'(2);
        fr_bytes = {resp_code(op_q), reg_q, 32'h0};
      end else begin
        fr_len   = LW'(6);
        fr_bytes = {resp_code(op_q), reg_q, rd_val};
      end
    end else if (((st == P_LEN) && rx_valid && (rx_data == 8'h00)) ||
                 ((st == P_PAY) && rx_valid && (left_q == 8'd1))) begin
      fr_load  = 1'b1;
      fr_len   = LW'(2);
      fr_bytes = {resp_code(OP_USER), (st == P_LEN) ? 8'h00 : len_q, 32'h0};
    end
  end

  // frame parser
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= P_OP;
      op_q   <= '0;
      reg_q  <= '0;
      len_q  <= '0;
      left_q <= '0;
      wdat_q <= '0;
      dcnt_q <= '0;
    end else if (ev_timeout) begin
      st <= P_OP;
    end else begin
      unique case (st)
        P_OP: if (rx_valid) begin
          op_q <= rx_data;
          if (is_reg_op(rx_data))      st <= P_REG;
          else if (rx_data == OP_USER) st <= P_LEN;
          else                         st <= P_SEND;
        end
        P_REG: if (rx_valid) begin
          reg_q  <= rx_data;
          dcnt_q <= '0;
          st     <= rx_data[7] ? P_DATA : P_EXEC;
        end
        P_DATA: if (rx_valid) begin
          wdat_q <= {wdat_q[23:0], rx_data};
          dcnt_q <= dcnt_q + 2'd1;
          if (dcnt_q == 2'd3) st <= P_EXEC;
        end
        P_EXEC: st <= P_SEND;
        P_LEN: if (rx_valid) begin
          len_q  <= rx_data;
          left_q <= rx_data;
          st     <= (rx_data == 8'h00) ? P_SEND : P_PAY;
        end
        P_PAY: if (rx_valid) begin
          left_q <= left_q - 8'd1;
          if (left_q == 8'd1) st <= P_SEND;
        end
        P_SEND: if (!tx_busy) st <= P_OP;
        default: st <= P_OP;
      endcase
    end
  end

  dce_idle_timer #(.W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(parsing), .kick(rx_valid),
    .limit(idle_limit), .expire(ev_timeout)
  );

  dce_tx_frame #(.MAXB(RSP_MAX_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(fr_load), .bytes(fr_bytes), .len(fr_len),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .busy(tx_busy)
  );

  assign cnt_inc[CI_UNK]  = ev_unknown;
  assign cnt_inc[CI_VIOL] = ev_viol;
  assign cnt_inc[CI_TMO]  = ev_timeout;
  assign cnt_inc[CI_RXB]  = rx_valid;
  assign cnt_inc[CI_TXB]  = ev_txb;
  assign cnt_inc[CI_FRM]  = ev_frame;

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    dce_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[gi]), .val(cnt_val[gi])
    );
  end

  // R3
  wr_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_unit == 2'd0) && !tx_valid);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd, usr_valid}));
  // R12
  tx_in_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (st == P_SEND));
  // R8
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (st == P_OP) && !tx_valid);
  // R4
  rd_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> tx_valid && (tx_data == 8'h04));
endmodule

// File: tb/sim_dbg_cmd_engine.sv
`timescale 1ns/1ps
module sim_dbg_cmd_engine;
  localparam int CW = 8;
  localparam int TW = 8;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] idle_limit = 8'd20;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_valid, tx_ready = 1'b1;
  logic [7:0] tx_data;
  logic reg_wr, reg_rd, usr_valid;
  logic [1:0] reg_unit;
  logic [6:0] reg_num;
  logic [31:0] reg_wdata, reg_rdata;
  logic [7:0] usr_data;

  always #10 clk = ~clk;

  // status bank model
  assign reg_rdata = {16'hC0DE, 9'h000, reg_num};

  dbg_cmd_engine #(.CNT_W(CW), .TMO_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .idle_limit(idle_limit),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_unit(reg_unit), .reg_num(reg_num),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .usr_valid(usr_valid), .usr_data(usr_data)
  );

  int n_chk = 0, n_err = 0;
  int m_rx = 0, m_tx = 0, m_fr = 0, m_unk = 0, m_viol = 0, m_tmo = 0;
  logic [7:0] cap [0:4095];
  logic [7:0] ubuf [0:511];
  int cap_n = 0, usr_n = 0, wr_n = 0, rd_n = 0;
  logic [6:0] wr_num, rd_num;
  logic [1:0] wr_unit, rd_unit;
  logic [31:0] wr_dat;
  bit finished = 0;

  always @(negedge clk) if (rst_n) begin
    if (tx_valid && tx_ready) begin cap[cap_n % 4096] = tx_data; cap_n++; m_tx++; end
    if (usr_valid) begin ubuf[usr_n % 512] = usr_data; usr_n++; end
    if (reg_wr) begin wr_n++; wr_num = reg_num; wr_dat = reg_wdata; wr_unit = reg_unit; end
    if (reg_rd) begin rd_n++; rd_num = reg_num; rd_unit = reg_unit; end
  end

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = b; m_rx++;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_resp(input int base, input int n, input logic [47:0] exp, input string req);
    int w = 0;
    while (cap_n < base + n && w < 400) begin @(negedge clk); w++; end
    idle(4);
    chk(cap_n == base + n, {req, " response length"}, cap_n - base, n);
    for (int i = 0; i < n; i++)
      chk(cap[(base + i) % 4096] == exp[47 - 8*i -: 8], {req, " response byte"},
          cap[(base + i) % 4096], exp[47 - 8*i -: 8]);
    m_fr++;
  endtask

  task automatic read_reg(input logic [7:0] op, input logic [7:0] num,
                          input logic [31:0] expv, input string req);
    int base = cap_n;
    send_byte(op); send_byte(num);
    expect_resp(base, 6, {op + 8'd1, num, expv}, req);
  endtask

  task automatic t_reset;
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(reg_wr == 1'b0 && reg_rd == 1'b0, "R1 strobes", {reg_wr, reg_rd}, 0);
    chk(usr_valid == 1'b0, "R1 usr_valid", usr_valid, 0);
    read_reg(8'h07, 8'h00, 32'd0, "R1 unknown count");
    read_reg(8'h09, 8'h02, 32'd1, "R1 frame count");
  endtask

  task automatic t_ctrl_write;
    int base = cap_n; int w0 = wr_n;
    send_byte(8'h01); send_byte(8'h85);
    send_byte(8'hDE); send_byte(8'hAD); send_byte(8'hBE); send_byte(8'hEF);
    expect_resp(base, 2, {8'h02, 8'h85, 32'h0}, "R3 ack");
    chk(wr_n == w0 + 1, "R3 one write pulse", wr_n - w0, 1);
    chk(wr_num == 7'd5 && wr_unit == 2'd0, "R2 write decode", {wr_unit, wr_num}, {2'd0, 7'd5});
    chk(wr_dat == 32'hDEADBEEF, "R3 write data MSB first", wr_dat, 32'hDEADBEEF);
  endtask

  task automatic t_stat_read;
    int r0 = rd_n;
    read_reg(8'h03, 8'h12, 32'hC0DE0012, "R4 status read");
    chk(rd_n == r0 + 1, "R4 one read pulse", rd_n - r0, 1);
    chk(rd_num == 7'h12 && rd_unit == 2'd1, "R4 read decode", {rd_unit, rd_num}, {2'd1, 7'h12});
  endtask

  task automatic t_unknown;
    int base = cap_n; int w0 = wr_n; int r0 = rd_n;
    send_byte(8'h2A);
    expect_resp(base, 2, {8'h08, 8'h01, 32'h0}, "R5 unknown opcode");
    m_unk++;
    chk(wr_n == w0 && rd_n == r0, "R5 no strobe", wr_n + rd_n, w0 + r0);
  endtask

  task automatic t_viol;
    int base; int w0 = wr_n; int r0 = rd_n;
    base = cap_n;
    send_byte(8'h01); send_byte(8'h03);
    expect_resp(base, 2, {8'h08, 8'h02, 32'h0}, "R6 read of control");
    m_viol++;
    base = cap_n;
    send_byte(8'h03); send_byte(8'h81);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    expect_resp(base, 2, {8'h08, 8'h02, 32'h0}, "R6 write of status");
    m_viol++;
    chk(wr_n == w0 && rd_n == r0, "R6 no strobe", wr_n + rd_n, w0 + r0);
  endtask

  task automatic t_user;
    int base = cap_n; int u0n = usr_n;
    send_byte(8'h05); send_byte(8'h03);
    send_byte(8'hAA); send_byte(8'h55); send_byte(8'h0F);
    expect_resp(base, 2, {8'h06, 8'h03, 32'h0}, "R7 user ack");
    chk(usr_n == u0n + 3, "R7 payload count", usr_n - u0n, 3);
    chk({ubuf[u0n % 512], ubuf[(u0n+1) % 512], ubuf[(u0n+2) % 512]} == 24'hAA550F,
        "R7 payload order", {ubuf[u0n % 512], ubuf[(u0n+1) % 512], ubuf[(u0n+2) % 512]}, 24'hAA550F);
    base = cap_n;
    send_byte(8'h05); send_byte(8'h00);
    expect_resp(base, 2, {8'h06, 8'h00, 32'h0}, "R7 empty user frame");
  endtask

  task automatic t_timeout;
    int base = cap_n; int w0 = wr_n;
    send_byte(8'h01); send_byte(8'h85); send_byte(8'h11);
    idle(40);
    chk(cap_n == base, "R8 no response after timeout", cap_n - base, 0);
    chk(wr_n == w0, "R8 partial write discarded", wr_n - w0, 0);
    m_tmo++;
    read_reg(8'h07, 8'h02, 32'(m_tmo), "R8 timeout count");
    idle_limit = 8'd0;
    base = cap_n;
    send_byte(8'h03);
    idle(40);
    chk(cap_n == base, "R8 disabled timer waits", cap_n - base, 0);
    send_byte(8'h07);
    expect_resp(base, 6, {8'h04, 8'h07, 32'hC0DE0007}, "R8 frame survives with limit 0");
    idle_limit = 8'd20;
  endtask

  task automatic t_err_regs;
    read_reg(8'h07, 8'h00, 32'(sat(m_unk)), "R9 unknown count");
    read_reg(8'h07, 8'h01, 32'(sat(m_viol)), "R9 violation count");
    read_reg(8'h07, 8'h05, 32'd0, "R9 unused register");
  endtask

  task automatic t_stats;
    logic [31:0] e;
    e = 32'(sat(m_rx + 2));
    read_reg(8'h09, 8'h00, e, "R10 rx bytes");
    e = 32'(sat(m_tx));
    read_reg(8'h09, 8'h01, e, "R10 tx bytes");
    e = 32'(sat(m_fr));
    read_reg(8'h09, 8'h02, e, "R10 frames");
  endtask

  task automatic t_backpressure;
    int base = cap_n; bit stable_ok = 1; logic [7:0] held;
    tx_ready = 1'b0;
    send_byte(8'h03); send_byte(8'h21);
    while (!tx_valid) @(negedge clk);
    held = tx_data;
    send_byte(8'h2A);
    repeat (5) begin @(negedge clk); if (tx_data != held || !tx_valid) stable_ok = 0; end
    chk(stable_ok, "R12 data held under backpressure", tx_data, held);
    @(posedge clk); #1; tx_ready = 1'b1;
    expect_resp(base, 6, {8'h04, 8'h21, 32'hC0DE0021}, "R12 response after stall");
    read_reg(8'h07, 8'h00, 32'(sat(m_unk)), "R12 dropped byte not parsed");
  endtask

  task automatic t_sat;
    int base = cap_n; int u0n = usr_n;
    send_byte(8'h05); send_byte(8'hFF);
    for (int i = 0; i < 255; i++) send_byte(8'(i));
    expect_resp(base, 2, {8'h06, 8'hFF, 32'h0}, "R7 full length user frame");
    chk(usr_n == u0n + 255, "R7 255 payload bytes", usr_n - u0n, 255);
    chk(ubuf[(u0n + 254) % 512] == 8'hFE, "R7 last payload byte", ubuf[(u0n + 254) % 512], 8'hFE);
    read_reg(8'h09, 8'h00, 32'(MAXV), "R11 rx count saturates");
    read_reg(8'h09, 8'h01, 32'(sat(m_tx)), "R11 tx count");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_ctrl_write();
    t_stat_read();
    t_unknown();
    t_viol();
    t_user();
    t_timeout();
    t_err_regs();
    t_stats();
    t_backpressure();
    t_sat();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule